// File: doc/BRIEF.md
# Hot-Swap Handle Monitor and Status Register

This block is the single-byte control and status register a peripheral board uses to take part in live insertion and removal. It samples the raw ejector-handle switch, synchronises and filters it, and turns each filtered transition into a sticky event flag. A flag for "board seated" is raised when the handle is found closed after reset. A flag for "removal requested" is raised when a closed handle is opened.

While either flag is pending and the alert mask is clear, the block pulls an open-drain enumeration alert line low so that host software notices the change. Software reads the register over a small local bus (chip select, read and write strobes, 8-bit data), clears flags by writing ones to them, sets the alert mask, and owns a lamp bit that drives the blue hot-swap indicator. The lamp comes up lit out of reset, so the board shows that it may be removed until software takes control.

Top module: `hswap_csr`

## Requirements
- R1: After reset the register reads 0x08: lamp bit 1, mask bit 0, both flags 0. The lamp output is 1 and the alert line is released (high impedance).
- R2: A read (cs=1, rd=1) returns the seated flag in bit 7, the removal flag in bit 6, the lamp bit in bit 3 and the alert mask in bit 1. All other bits read 0, and rdata is 0x00 whenever no read is in progress.
- R3: When the filtered handle goes from open to closed, the seated flag (bit 7) is set. The filtered state is open at reset, so a handle already closed at reset sets the flag.
- R4: When the filtered handle goes from closed to open, the removal flag (bit 6) is set.
- R5: A handle level that differs from the filtered state for fewer than DEB_CYCLES consecutive synchronised samples changes neither the filtered state nor any flag.
- R6: Writing 1 to bit 7 or bit 6 clears that flag. Writing 0 there leaves it unchanged.
- R7: If a clearing write and a new event for the same flag fall in the same clock cycle, the flag stays set.
- R8: The alert line is driven low when either flag is set and the mask bit is 0. Otherwise it is released.
- R9: Every write loads the lamp bit from wdata bit 3 and the mask bit from wdata bit 1. The lamp output follows the lamp bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Register select |
| wr | input | 1 | Write strobe, qualified by cs |
| rd | input | 1 | Read strobe, qualified by cs |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, zero when not reading |
| handle_open | input | 1 | Raw handle switch, 1 = open |
| lamp_on | output | 1 | Blue indicator drive, 1 = lit |
| alert_n | output | 1 | Open-drain enumeration alert, low or high impedance |

## Verification
The bench aims a clearing write at the exact cycle in which a new removal event lands. A design that let the clear win would lose that event and read bit 6 as 0. A two-cycle handle glitch checks the filter: a design without a proper debounce would raise a spurious flag. The bench writes zeros to a pending flag while it changes the mask, and a design that cleared on any write would drop the flag at that point. It also watches the alert line through a pull-up after masking and after clearing. A design that left the line driven, or gated it the wrong way, would read low where high is expected.

// File: rtl/hswap_pkg.sv
package hswap_pkg;
   localparam int unsigned REG_W     = 8;
   localparam int unsigned BIT_SEAT  = 7;
   localparam int unsigned BIT_LEAVE = 6;
   localparam int unsigned BIT_LAMP  = 3;
   localparam int unsigned BIT_MASK  = 1;

   typedef struct packed {
      logic seated;
      logic leaving;
      logic lamp;
      logic mask;
   } hswap_state_t;
endpackage

// File: rtl/hswap_debounce.sv
module hswap_debounce #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DEB_CYCLES  = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_open,
   output logic ev_close,
   output logic ev_open
);
   localparam int unsigned CNT_W = (DEB_CYCLES > 1) ? $clog2(DEB_CYCLES) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_CYCLES - 1);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("hswap_debounce: SYNC_STAGES must be at least 2");
   end
   if (DEB_CYCLES < 1) begin : g_bad_deb
      $error("hswap_debounce: DEB_CYCLES must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   samp;
   logic                   stable_q;
   logic                   differs;
   logic                   accept;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_open};
   end
   assign samp    = sync_q[SYNC_STAGES-1];
   assign differs = (samp != stable_q);

   if (DEB_CYCLES == 1) begin : g_direct
      assign accept = differs;
   end else begin : g_counted
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)               cnt_q <= '0;
         else if (!differs)        cnt_q <= '0;
         else if (cnt_q == CNT_LAST) cnt_q <= '0;
         else                      cnt_q <= cnt_q + 1'b1;
      end
      assign accept = differs && (cnt_q == CNT_LAST);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stable_q <= 1'b1;
      else if (accept) stable_q <= samp;
   end

   assign ev_close = accept && !samp;
   assign ev_open  = accept &&  samp;

   // the filtered state only ever moves to the synchronised level
   assert_filter_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (stable_q != $past(stable_q)) |-> ($past(samp) == stable_q));
endmodule

// File: rtl/hswap_status.sv
module hswap_status
   import hswap_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ev_close,
   input  logic               ev_open,
   input  logic               wr_en,
   input  logic [REG_W-1:0]   wdata,
   output hswap_state_t       st
);
   hswap_state_t st_q;
   logic clr_seat, clr_leave;

   assign clr_seat  = wr_en && wdata[BIT_SEAT];
   assign clr_leave = wr_en && wdata[BIT_LEAVE];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q.seated  <= 1'b0;
         st_q.leaving <= 1'b0;
         st_q.lamp    <= 1'b1;
         st_q.mask    <= 1'b0;
      end else begin
         if (ev_close)      st_q.seated <= 1'b1;
         else if (clr_seat) st_q.seated <= 1'b0;
         if (ev_open)        st_q.leaving <= 1'b1;
         else if (clr_leave) st_q.leaving <= 1'b0;
         if (wr_en) begin
            st_q.lamp <= wdata[BIT_LAMP];
            st_q.mask <= wdata[BIT_MASK];
         end
      end
   end
   assign st = st_q;

   assert_seat_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ev_close |=> st_q.seated);
   assert_leave_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ev_open |=> st_q.leaving);
   assert_w1c_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_seat && !ev_close) |=> !st_q.seated);
   assert_sticky_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q.leaving && !clr_leave) |=> st_q.leaving);
   assert_event_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_leave && ev_open) |=> st_q.leaving);
   assert_lamp_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (st_q.lamp == $past(wdata[BIT_LAMP])));
endmodule

// File: rtl/hswap_csr.sv
module hswap_csr
   import hswap_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DEB_CYCLES  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs,
   input  logic             wr,
   input  logic             rd,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata,
   input  logic             handle_open,
   output logic             lamp_on,
   output tri               alert_n
);
   logic         ev_close, ev_open;
   hswap_state_t st;
   logic         pull_low;
   logic [REG_W-1:0] view;

   hswap_debounce #(.SYNC_STAGES(SYNC_STAGES), .DEB_CYCLES(DEB_CYCLES)) i_deb (
      .clk(clk), .rst_n(rst_n), .raw_open(handle_open),
      .ev_close(ev_close), .ev_open(ev_open));

   hswap_status i_stat (
      .clk(clk), .rst_n(rst_n), .ev_close(ev_close), .ev_open(ev_open),
      .wr_en(cs && wr), .wdata(wdata), .st(st));

   always_comb begin
      view            = '0;
      view[BIT_SEAT]  = st.seated;
      view[BIT_LEAVE] = st.leaving;
      view[BIT_LAMP]  = st.lamp;
      view[BIT_MASK]  = st.mask;
   end

   assign rdata    = (cs && rd) ? view : '0;
   assign lamp_on  = st.lamp;
   assign pull_low = (st.seated || st.leaving) && !st.mask;
   assign alert_n  = pull_low ? 1'b0 : 1'bz;

   // a flag can only appear through a filtered event
   assert_seat_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st.seated) |-> $past(ev_close));
endmodule

// File: tb/test_hswap_csr.sv
module test_hswap_csr;
   localparam int CLK_PERIOD = 10;
   localparam int DEB        = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs = 1'b0, wr = 1'b0, rd = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic handle_open = 1'b1;
   logic lamp_on;
   tri   alert_line;
   pullup (alert_line);

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   hswap_csr #(.SYNC_STAGES(2), .DEB_CYCLES(DEB)) i_hswap_csr (
      .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .rd(rd), .wdata(wdata),
      .rdata(rdata), .handle_open(handle_open), .lamp_on(lamp_on),
      .alert_n(alert_line));

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct packed {
      logic       handle;
      logic       do_wr;
      logic [7:0] wd;
      logic [7:0] exp_rd;
      logic       exp_alert;
      logic [7:0] req;
   } row_t;

   // reg map: bit7 seated, bit6 leaving, bit3 lamp, bit1 mask
   localparam int NROWS = 7;
   localparam row_t ROWS [NROWS] = '{
      '{1'b1, 1'b0, 8'h00, 8'h08, 1'b1, 8'd2},  // R2 idle read, open handle
      '{1'b0, 1'b0, 8'h00, 8'h88, 1'b0, 8'd3},  // R3 handle closes, R8 alert low
      '{1'b0, 1'b1, 8'h80, 8'h00, 1'b1, 8'd6},  // R6 clear seated, R9 lamp off
      '{1'b1, 1'b0, 8'h00, 8'h40, 1'b0, 8'd4},  // R4 handle opens
      '{1'b1, 1'b1, 8'h02, 8'h42, 1'b1, 8'd8},  // R8 masked, R6 zero keeps flag
      '{1'b1, 1'b1, 8'h0A, 8'h4A, 1'b1, 8'd9},  // R9 lamp back on
      '{1'b1, 1'b1, 8'h48, 8'h08, 1'b1, 8'd6}   // R6 clear leaving
   };

   task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic read_reg(output logic [7:0] v);
      @(negedge clk);
      cs = 1'b1; rd = 1'b1;
      #1 v = rdata;
      @(negedge clk);
      cs = 1'b0; rd = 1'b0;
   endtask

   task automatic write_reg(input logic [7:0] v);
      @(negedge clk);
      cs = 1'b1; wr = 1'b1; wdata = v;
      @(negedge clk);
      cs = 1'b0; wr = 1'b0; wdata = 8'h00;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      #1;
      check8("R1 lamp", {7'd0, lamp_on}, 8'h01);
      check8("R1 alert", {7'd0, alert_line}, 8'h01);
      read_reg(v);
      check8("R1 reset read", v, 8'h08);
      // R2 bus idle gives zero
      #1 check8("R2 idle rdata", rdata, 8'h00);

      for (int i = 0; i < NROWS; i++) begin
         @(negedge clk);
         handle_open = ROWS[i].handle;
         if (ROWS[i].do_wr) write_reg(ROWS[i].wd);
         repeat (DEB + 8) @(posedge clk);
         read_reg(v);
         check8($sformatf("R%0d row %0d read", ROWS[i].req, i), v, ROWS[i].exp_rd);
         check8($sformatf("R%0d row %0d alert", ROWS[i].req, i),
                {7'd0, alert_line}, {7'd0, ROWS[i].exp_alert});
         check8($sformatf("R9 row %0d lamp", i), {7'd0, lamp_on}, {7'd0, ROWS[i].exp_rd[3]});
      end

      // R5 short glitch toward closed is ignored
      @(negedge clk); handle_open = 1'b0;
      repeat (2) @(negedge clk);
      handle_open = 1'b1;
      repeat (DEB + 8) @(posedge clk);
      read_reg(v);
      check8("R5 glitch ignored", v, 8'h08);
      check8("R5 alert after glitch", {7'd0, alert_line}, 8'h01);

      // build up both flags: close, open, close again
      @(negedge clk); handle_open = 1'b0;
      repeat (DEB + 8) @(posedge clk);
      @(negedge clk); handle_open = 1'b1;
      repeat (DEB + 8) @(posedge clk);
      read_reg(v);
      check8("R4 both flags", v, 8'hC8);
      @(negedge clk); handle_open = 1'b0;
      repeat (DEB + 8) @(posedge clk);

      // R7 clear of leaving lands in the same cycle as a new open event
      @(negedge clk); handle_open = 1'b1;
      repeat (DEB + 1) @(posedge clk);
      @(negedge clk);
      cs = 1'b1; wr = 1'b1; wdata = 8'h48;
      @(negedge clk);
      cs = 1'b0; wr = 1'b0; wdata = 8'h00;
      read_reg(v);
      check8("R7 event beats clear", v, 8'hC8);
      check8("R8 alert with flags", {7'd0, alert_line}, 8'h00);

      // R6 clear both with one write, R8 line released
      write_reg(8'hCA);
      read_reg(v);
      check8("R6 clear both", v, 8'h0A);
      check8("R8 released masked", {7'd0, alert_line}, 8'h01);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule